// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Latched Byte Reads

This block is a 16-bit up-counter driven through a power-of-two prescaler and reached over an 8-bit register bus. A processor with byte-wide loads configures it through two control bytes. It can stop, start and preload it, and it reads the count as two separate bytes. When the timer is running, a read of the high byte freezes a copy of the low byte. The two byte reads then describe the same instant, even when a carry passes between them.

Byte writes go straight into the live counter on the next edge, and counting carries on from the written value. No write staging exists, so preloading a full 16-bit value is safe only while the timer is stopped. The control bytes also hold a 4-bit operating-mode code. The code is split across the two bytes and presented on an output for the logic that implements each mode. Inside this block the counter only counts freely and wraps.

Top module: `ptimer8`

## Requirements
- R1: After reset the count, the holding byte, the prescaler, both control bytes and `mode_o` are zero, and every register address reads 0x00.
- R2: Address 2 (control A) and address 3 (control B) read back exactly the byte last written. `mode_o` is {control A bit 7, control B bits 2:0}, and every code from 0 to 10 is carried through unchanged.
- R3: Control B bit 7 is the run enable and control B bits 5:3 are the prescale code p. While the timer is enabled, the count rises by one on every 2^p-th enabled clock edge, so N enabled edges starting from a cleared prescaler add floor(N / 2^p).
- R4: The prescaler is cleared on every edge where the timer is disabled, so a restart always waits a full 2^p enabled edges before its first increment.
- R5: The count wraps from 0xFFFF to 0x0000 and continues counting.
- R6: While the timer is enabled, a read of address 0 (high byte) stores the current low byte in a holding register. While the timer is enabled, a read of address 1 (low byte) returns that holding register and not the live low byte.
- R7: While the timer is disabled, address 1 returns the live low byte of the count and address 0 returns the live high byte.
- R8: A write to address 0 or address 1 replaces that half of the count at the next edge, and counting continues from the new value. If an increment falls on the same edge, the unwritten half keeps its current value, with no carry into it and no roll-over from it.
- R9: While the timer is disabled and no count byte is written, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 high count, 1 low count, 2 control A, 3 control B |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| mode_o | output | 4 | Stored operating-mode code |

## Verification
The hardest case to reach is a byte write that lands on the same edge as a prescaler increment that would carry between the halves. Reaching it needs the bus timing and the prescaler phase aligned exactly. The bench preloads 0x00FF while the timer is stopped and enables it with divide-by-1, so every enabled edge increments. It then writes one count byte on the first enabled edge, stops the timer one edge later, and reads the result with direct reads. The latched-read case is reached the same way: a preload just below a low-byte roll-over, so the live and held low bytes visibly differ when the held one is read.

// File: rtl/ptimer8.sv
module ptimer8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [3:0] mode_o
);
  localparam int CNT_W = 16;
  localparam int HALF_W = CNT_W / 2;
  localparam int PRE_W = 7;
  localparam logic [1:0] A_HI = 2'd0, A_LO = 2'd1, A_CA = 2'd2, A_CB = 2'd3;

  logic [7:0]       ctla_q, ctlb_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;

  wire             en    = ctlb_q[7];
  wire [2:0]       pres  = ctlb_q[5:3];
  wire [PRE_W:0]   lim   = (PRE_W'(1) << pres) - 1'b1;
  wire             tick  = en && (pre_q == lim[PRE_W-1:0]);
  wire [CNT_W-1:0] nxt   = tick ? cnt_q + 1'b1 : cnt_q;
  wire             wr_hi = wr_en && addr == A_HI;
  wire             wr_lo = wr_en && addr == A_LO;

  assign mode_o = {ctla_q[7], ctlb_q[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else if (!en || tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q[CNT_W-1:HALF_W] <= wr_hi ? wdata : (wr_lo ? cnt_q[CNT_W-1:HALF_W] : nxt[CNT_W-1:HALF_W]);
      cnt_q[HALF_W-1:0]     <= wr_lo ? wdata : (wr_hi ? cnt_q[HALF_W-1:0] : nxt[HALF_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla_q <= '0;
      ctlb_q <= '0;
      hold_q <= '0;
    end else begin
      if (wr_en && addr == A_CA) ctla_q <= wdata;
      if (wr_en && addr == A_CB) ctlb_q <= wdata;
      if (rd_en && addr == A_HI && en) hold_q <= cnt_q[HALF_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      A_HI:    rdata = cnt_q[CNT_W-1:HALF_W];
      A_LO:    rdata = en ? hold_q : cnt_q[HALF_W-1:0];
      A_CA:    rdata = ctla_q;
      default: rdata = ctlb_q;
    endcase
  end
endmodule

// File: rtl/ptimer8_chk.sv
module ptimer8_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        en,
  input logic [6:0]  pre_q,
  input logic [15:0] cnt_q,
  input logic [7:0]  hold_q
);
  // R4
  prescale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_q == 7'd0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt_q));
  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_en) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1));
  // R8
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (cnt_q[15:8] == $past(wdata) && cnt_q[7:0] == $past(cnt_q[7:0])));
  // R8
  write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (cnt_q[7:0] == $past(wdata) && cnt_q[15:8] == $past(cnt_q[15:8])));
  // R6
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && en) |=> hold_q == $past(cnt_q[7:0]));
  // R7
  live_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && addr == 2'd1) |-> rdata == cnt_q[7:0]);
endmodule

bind ptimer8 ptimer8_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .en(en), .pre_q(pre_q), .cnt_q(cnt_q), .hold_q(hold_q)
);

// File: tb/ptimer8_tb_top.sv
`timescale 1ns/1ps
module ptimer8_tb_top;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [3:0] mode_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptimer8 dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
                 .wdata(wdata), .rdata(rdata), .mode_o(mode_o));

  localparam int NV = 8;
  localparam logic [2:0]  VP [NV] = '{3'd0, 3'd1, 3'd3, 3'd7, 3'd7, 3'd0, 3'd2, 3'd4};
  localparam int          VN [NV] = '{5, 7, 16, 255, 256, 3, 4, 33};
  localparam logic [15:0] VS [NV] = '{16'h0000, 16'h0010, 16'h00FF, 16'h1234, 16'h1234, 16'hFFFE, 16'h00FE, 16'h0000};
  localparam logic [15:0] VE [NV] = '{16'h0005, 16'h0013, 16'h0101, 16'h1235, 16'h1236, 16'h0001, 16'h00FF, 16'h0002};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd_reg(2'd0, h);
    rd_reg(2'd1, l);
    v = {h, l};
  endtask

  task automatic set16(input logic [15:0] v);
    wr_reg(2'd0, v[15:8]);
    wr_reg(2'd1, v[7:0]);
  endtask

  task automatic run(input logic [2:0] p, input int n);
    wr_reg(2'd3, {2'b10, p, 3'b000});
    repeat (n - 1) @(negedge clk);
    wr_reg(2'd3, 8'h00);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], b);
      chk("R1", {8'h00, b}, 16'h0000);
    end
    chk("R1 mode", {12'h0, mode_o}, 16'h0000);

    // R3 R5 table of prescale runs
    for (int i = 0; i < NV; i++) begin
      set16(VS[i]);
      run(VP[i], VN[i]);
      rd16(v);
      chk(VS[i] == 16'hFFFE ? "R5 wrap" : "R3 prescale", v, VE[i]);
    end

    // R2 control readback and mode code
    wr_reg(2'd2, 8'hA5);
    wr_reg(2'd3, 8'h2A);
    rd_reg(2'd2, b); chk("R2 ctlA", {8'h00, b}, 16'h00A5);
    rd_reg(2'd3, b); chk("R2 ctlB", {8'h00, b}, 16'h002A);
    chk("R2 mode", {12'h0, mode_o}, 16'h000A);
    for (int m = 0; m < 11; m++) begin
      wr_reg(2'd2, {m[3], 7'h00});
      wr_reg(2'd3, {5'b00000, m[2:0]});
      chk("R2 mode code", {12'h0, mode_o}, 16'(m));
    end
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h00);

    // R4 prescaler cleared on disable
    set16(16'h0000);
    run(3'd2, 3);
    run(3'd2, 3);
    rd16(v); chk("R4 restart", v, 16'h0000);
    run(3'd2, 4);
    rd16(v); chk("R4 full period", v, 16'h0001);

    // R6 R7 latched reads
    set16(16'h12FE);
    wr_reg(2'd3, 8'h80);
    rd_reg(2'd0, b); chk("R6 hi", {8'h00, b}, 16'h0012);
    rd_reg(2'd1, b); chk("R6 held lo", {8'h00, b}, 16'h00FE);
    rd_reg(2'd0, b); chk("R6 hi2", {8'h00, b}, 16'h0013);
    rd_reg(2'd1, b); chk("R6 held lo2", {8'h00, b}, 16'h0000);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd1, b); chk("R7 live lo", {8'h00, b}, 16'h0003);
    rd_reg(2'd0, b); chk("R7 live hi", {8'h00, b}, 16'h0013);

    // R8 writes colliding with increments
    set16(16'h00FF);
    wr_reg(2'd3, 8'h80);
    wr_reg(2'd1, 8'h10);
    wr_reg(2'd3, 8'h00);
    rd16(v); chk("R8 lo write", v, 16'h0011);
    set16(16'h00FF);
    wr_reg(2'd3, 8'h80);
    wr_reg(2'd0, 8'h40);
    wr_reg(2'd3, 8'h00);
    rd16(v); chk("R8 hi write", v, 16'h4100);

    // R9 disabled counter holds
    set16(16'h5A5A);
    repeat (20) @(negedge clk);
    rd16(v); chk("R9 hold", v, 16'h5A5A);

    // R1 reset mid-run
    wr_reg(2'd3, 8'h80);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd16(v); chk("R1 re-reset", v, 16'h0000);
    chk("R1 re-reset mode", {12'h0, mode_o}, 16'h0000);

    finish_up();
  end
endmodule